// File: doc/BRIEF.md
# Ethernet Frame Header Classifier

This block watches a received or transmitted frame go by as a stream of 16-bit halfwords, one per valid strobe. It keeps a running halfword index and decides the link-layer framing. That framing is either a type-coded frame or a length-coded frame, and it may carry a single VLAN tag. The block then decodes the network protocol and, for IP, the transport protocol. It does this without holding more than the word currently on its input.

The results appear as three groups of one-hot flags: link, network and transport. The block also drives two per-halfword strobes that a checksum engine and a payload mover run beside it. The first strobe marks every halfword that belongs to a TCP or UDP segment. The second pulses on the halfword where application data begins. For TCP, that point depends on the header length carried inside the TCP header itself.

A start-of-frame input, given together with the first halfword, restarts the index and clears the flags. The flags stay put between frames, so they can be read after the last halfword.

Top module: `frame_hdr_classifier`

## Requirements
- R1: A halfword is taken only when `hw_valid_i` is high; the one taken with `sof_i` high has index 0. After reset, words taken before the first start-of-frame change no output.
- R2: The halfword at index 6 is the type/length word. A value of 0x0600 or more sets `l2_kind_o` bit 0 (type-coded frame). A smaller value sets bit 1 (length-coded frame) and leaves the network and transport flags zero.
- R3: A value of 0x8100 at index 6 sets `vlan_o`. The type/length decision then moves to index 8, and every later header position shifts by two halfwords.
- R4: The decoded type sets one `l3_kind_o` bit: 0x0800 bit 0 (IPv4), 0x86DD bit 1 (IPv6), 0x0806 bit 2 (ARP), 0x8035 bit 3 (RARP), 0x8137 bit 4 (IPX). Any other value sets none.
- R5: For IPv4, bits [11:8] of network halfword 0 give the header length in 32-bit units; the header spans twice that many halfwords, and a value below 5 counts as 5. Bits [7:0] of network halfword 4 select the transport: 6 sets `l4_kind_o` bit 0 (TCP), 17 sets bit 1 (UDP), 1 sets bit 2 (ICMP).
- R6: For IPv6, the header is always 20 halfwords. Bits [15:8] of network halfword 3 select the transport: 6 gives TCP, 17 gives UDP, 58 gives ICMP.
- R7: `csum_tag_o` is high on every taken halfword from the first transport halfword to the end of the frame when the transport is TCP or UDP. It is never high for ICMP or for non-IP frames.
- R8: For UDP, `user_start_o` pulses exactly once, on transport halfword 4.
- R9: For TCP, bits [15:12] of transport halfword 6 give the header length in 32-bit units, with a value below 5 counted as 5. `user_start_o` pulses exactly once, on the halfword that is twice that value past the first transport halfword.
- R10: The flags change in the cycle after the halfword that decides them, are all zero in the cycle after a start-of-frame halfword, and hold between frames. Each flag group is one-hot or zero.
- R11: A cycle with `hw_valid_i` low does not advance the index and drives neither strobe.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | First halfword of a frame, qualified by `hw_valid_i` |
| hw_valid_i | input | 1 | Halfword strobe |
| hw_data_i | input | 16 | Frame halfword, first byte in bits [15:8] |
| l2_kind_o | output | 2 | Link flags: bit 0 type-coded, bit 1 length-coded |
| vlan_o | output | 1 | VLAN tag seen |
| l3_kind_o | output | 5 | Network flags: IPv4, IPv6, ARP, RARP, IPX (bit 0 up) |
| l4_kind_o | output | 3 | Transport flags: TCP, UDP, ICMP (bit 0 up) |
| csum_tag_o | output | 1 | Current halfword is part of a TCP/UDP segment |
| user_start_o | output | 1 | Current halfword is the first byte pair of user data |

## Verification
The in-line properties watch, on every cycle, that each flag group stays one-hot or zero and that a length-coded frame carries no network flag. They also check that a transport flag never appears without an IP flag, that the data marker only fires inside a tagged segment and never twice in a row, and that a start-of-frame word clears the flags on the next edge. Whether the data marker lands on the right halfword depends on the IHL, data offset, VLAN shift and clamping, and so does the first tagged halfword. Those positions, and the exact flag chosen for each type and protocol code, can only be shown by the bench's frames with known expected indices.

// File: rtl/hdrcls_pkg.sv
package hdrcls_pkg;

    localparam int HW_W = 16;
    localparam int L2_N = 2;
    localparam int L3_N = 5;
    localparam int L4_N = 3;

    // flag bit positions
    localparam int L2_TYPED  = 0;
    localparam int L2_LENGTH = 1;
    localparam int L3_IPV4   = 0;
    localparam int L3_IPV6   = 1;
    localparam int L4_TCP    = 0;
    localparam int L4_UDP    = 1;
    localparam int L4_ICMP   = 2;

    localparam logic [HW_W-1:0] TYPE_FLOOR = 16'h0600;
    localparam logic [HW_W-1:0] TYPE_VLAN  = 16'h8100;

    // network-layer type codes, indexed by l3 flag bit
    localparam logic [HW_W-1:0] L3_CODES [L3_N] = '{
        16'h0800, 16'h86DD, 16'h0806, 16'h8035, 16'h8137
    };

    localparam logic [7:0] PROTO_TCP   = 8'd6;
    localparam logic [7:0] PROTO_UDP   = 8'd17;
    localparam logic [7:0] PROTO_ICMP4 = 8'd1;
    localparam logic [7:0] PROTO_ICMP6 = 8'd58;

    localparam logic [3:0] MIN_HDR_WORDS = 4'd5;

    // halfword positions
    localparam int TYPE_POS      = 6;
    localparam int TAG_SHIFT     = 2;
    localparam int V4_PROTO_OFS  = 4;
    localparam int V6_NEXT_OFS   = 3;
    localparam int V6_HDR_HW     = 20;
    localparam int UDP_HDR_HW    = 4;
    localparam int TCP_LEN_OFS   = 6;

endpackage

// File: rtl/hdrcls_hw_counter.sv
module hdrcls_hw_counter #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_valid_i,
    input  logic             sof_i,
    output logic             active_o,
    output logic [IDX_W-1:0] cur_idx_o
);

    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        logic             in_frame;
        logic [IDX_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t c_d, c_q;

    assign active_o  = hw_valid_i && (sof_i || c_q.in_frame);
    assign cur_idx_o = sof_i ? '0 : c_q.cnt;

    always_comb begin
        c_d = c_q;
        if (active_o) begin
            c_d.in_frame = 1'b1;
            c_d.cnt      = (cur_idx_o == IDX_MAX) ? IDX_MAX : cur_idx_o + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    p_sof_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid_i && sof_i |=> c_q.cnt == IDX_W'(1));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_valid_i |=> $stable(c_q.cnt));

    p_idx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && !sof_i && c_q.cnt != IDX_MAX |=> c_q.cnt == $past(c_q.cnt) + IDX_W'(1));

endmodule

// File: rtl/hdrcls_type_dec.sv
module hdrcls_type_dec
    import hdrcls_pkg::*;
(
    input  logic [HW_W-1:0] type_word_i,
    output logic [L2_N-1:0] l2_o,
    output logic [L3_N-1:0] l3_o
);

    logic is_length;

    assign is_length = type_word_i < TYPE_FLOOR;
    assign l2_o      = is_length ? (L2_N'(1) << L2_LENGTH) : (L2_N'(1) << L2_TYPED);

    for (genvar k = 0; k < L3_N; k++) begin : g_l3
        assign l3_o[k] = !is_length && (type_word_i == L3_CODES[k]);
    end

endmodule

// File: rtl/hdrcls_parser.sv
module hdrcls_parser
    import hdrcls_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             sof_i,
    input  logic [IDX_W-1:0] cur_idx_i,
    input  logic [HW_W-1:0]  hw_data_i,
    output logic [L2_N-1:0]  l2_o,
    output logic             vlan_o,
    output logic [L3_N-1:0]  l3_o,
    output logic [L4_N-1:0]  l4_o,
    output logic             csum_tag_o,
    output logic             user_start_o
);

    localparam logic [IDX_W-1:0] TYPE_IDX  = IDX_W'(TYPE_POS);
    localparam logic [IDX_W-1:0] INNER_IDX = IDX_W'(TYPE_POS + TAG_SHIFT);

    typedef struct packed {
        logic [L2_N-1:0]  l2;
        logic             vlan;
        logic [L3_N-1:0]  l3;
        logic [L4_N-1:0]  l4;
        logic [IDX_W-1:0] n_idx;
        logic [IDX_W-1:0] t_idx;
        logic             t_known;
        logic [IDX_W-1:0] u_idx;
        logic             u_known;
    } parse_st_t;

    parse_st_t st_d, st_q;

    logic [L2_N-1:0]  dec_l2;
    logic [L3_N-1:0]  dec_l3;
    logic [3:0]       ihl_eff, doff_eff;
    logic [IDX_W-1:0] ihl_hw, doff_hw;

    hdrcls_type_dec u_type_dec (
        .type_word_i (hw_data_i),
        .l2_o        (dec_l2),
        .l3_o        (dec_l3)
    );

    function automatic logic [L4_N-1:0] map_l4(input logic [7:0] code, input logic is_v6);
        logic [L4_N-1:0] f;
        f          = '0;
        f[L4_TCP]  = (code == PROTO_TCP);
        f[L4_UDP]  = (code == PROTO_UDP);
        f[L4_ICMP] = is_v6 ? (code == PROTO_ICMP6) : (code == PROTO_ICMP4);
        return f;
    endfunction

    assign ihl_eff  = (hw_data_i[11:8]  < MIN_HDR_WORDS) ? MIN_HDR_WORDS : hw_data_i[11:8];
    assign doff_eff = (hw_data_i[15:12] < MIN_HDR_WORDS) ? MIN_HDR_WORDS : hw_data_i[15:12];
    assign ihl_hw   = IDX_W'({ihl_eff, 1'b0});
    assign doff_hw  = IDX_W'({doff_eff, 1'b0});

    always_comb begin
        st_d = st_q;
        if (active_i) begin
            if (sof_i) begin
                st_d = '0;
            end else begin
                // link layer: outer type word, or inner one after a tag
                if (cur_idx_i == TYPE_IDX) begin
                    if (hw_data_i == TYPE_VLAN) begin
                        st_d.vlan = 1'b1;
                    end else begin
                        st_d.l2    = dec_l2;
                        st_d.l3    = dec_l3;
                        st_d.n_idx = cur_idx_i + IDX_W'(1);
                    end
                end
                if (cur_idx_i == INNER_IDX && st_q.vlan) begin
                    st_d.l2    = dec_l2;
                    st_d.l3    = dec_l3;
                    st_d.n_idx = cur_idx_i + IDX_W'(1);
                end
                // network layer: where transport starts
                if (cur_idx_i == st_q.n_idx && st_q.l3[L3_IPV4]) begin
                    st_d.t_idx   = st_q.n_idx + ihl_hw;
                    st_d.t_known = 1'b1;
                end
                if (cur_idx_i == st_q.n_idx && st_q.l3[L3_IPV6]) begin
                    st_d.t_idx   = st_q.n_idx + IDX_W'(V6_HDR_HW);
                    st_d.t_known = 1'b1;
                end
                // network layer: which transport
                if (cur_idx_i == st_q.n_idx + IDX_W'(V4_PROTO_OFS) && st_q.l3[L3_IPV4]) begin
                    st_d.l4 = map_l4(hw_data_i[7:0], 1'b0);
                end
                if (cur_idx_i == st_q.n_idx + IDX_W'(V6_NEXT_OFS) && st_q.l3[L3_IPV6]) begin
                    st_d.l4 = map_l4(hw_data_i[15:8], 1'b1);
                end
                // transport layer: where user data starts
                if (st_q.t_known && st_q.l4[L4_UDP] && cur_idx_i == st_q.t_idx) begin
                    st_d.u_idx   = st_q.t_idx + IDX_W'(UDP_HDR_HW);
                    st_d.u_known = 1'b1;
                end
                if (st_q.t_known && st_q.l4[L4_TCP] &&
                    cur_idx_i == st_q.t_idx + IDX_W'(TCP_LEN_OFS)) begin
                    st_d.u_idx   = st_q.t_idx + doff_hw;
                    st_d.u_known = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l2_o   = st_q.l2;
    assign vlan_o = st_q.vlan;
    assign l3_o   = st_q.l3;
    assign l4_o   = st_q.l4;

    assign csum_tag_o   = active_i && !sof_i && st_q.t_known &&
                          (st_q.l4[L4_TCP] || st_q.l4[L4_UDP]) && (cur_idx_i >= st_q.t_idx);
    assign user_start_o = active_i && !sof_i && st_q.u_known && (cur_idx_i == st_q.u_idx);

    p_groups_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l2_o) && $onehot0(l3_o) && $onehot0(l4_o));

    p_sof_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        active_i && sof_i |=> l2_o == '0 && l3_o == '0 && l4_o == '0 && !vlan_o);

    p_length_no_net_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l2_o[L2_LENGTH] |-> l3_o == '0);

    p_l4_needs_ip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l4_o != '0 |-> (l3_o[L3_IPV4] || l3_o[L3_IPV6]));

    p_user_in_segment_r7: assert property (@(posedge clk) disable iff (!rst_n)
        user_start_o |-> csum_tag_o);

    p_user_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        user_start_o |=> !user_start_o);

endmodule

// File: rtl/frame_hdr_classifier.sv
module frame_hdr_classifier
    import hdrcls_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof_i,
    input  logic        hw_valid_i,
    input  logic [15:0] hw_data_i,
    output logic [1:0]  l2_kind_o,
    output logic        vlan_o,
    output logic [4:0]  l3_kind_o,
    output logic [2:0]  l4_kind_o,
    output logic        csum_tag_o,
    output logic        user_start_o
);

    logic             active;
    logic [IDX_W-1:0] cur_idx;

    hdrcls_hw_counter #(.IDX_W(IDX_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_valid_i (hw_valid_i),
        .sof_i      (sof_i),
        .active_o   (active),
        .cur_idx_o  (cur_idx)
    );

    hdrcls_parser #(.IDX_W(IDX_W)) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (active),
        .sof_i        (sof_i),
        .cur_idx_i    (cur_idx),
        .hw_data_i    (hw_data_i),
        .l2_o         (l2_kind_o),
        .vlan_o       (vlan_o),
        .l3_o         (l3_kind_o),
        .l4_o         (l4_kind_o),
        .csum_tag_o   (csum_tag_o),
        .user_start_o (user_start_o)
    );

endmodule

// File: tb/frame_hdr_classifier_tb_top.sv
module frame_hdr_classifier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        hw_valid = 1'b0;
    logic [15:0] hw_data = '0;
    logic [1:0]  l2_kind;
    logic        vlan;
    logic [4:0]  l3_kind;
    logic [2:0]  l4_kind;
    logic        csum_tag;
    logic        user_start;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    frame_hdr_classifier dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof_i        (sof),
        .hw_valid_i   (hw_valid),
        .hw_data_i    (hw_data),
        .l2_kind_o    (l2_kind),
        .vlan_o       (vlan),
        .l3_kind_o    (l3_kind),
        .l4_kind_o    (l4_kind),
        .csum_tag_o   (csum_tag),
        .user_start_o (user_start)
    );

    typedef struct packed {
        logic        vlan;
        logic [15:0] etype;
        logic [3:0]  ihl;
        logic [7:0]  proto;
        logic [3:0]  doff;
        logic [7:0]  nw;
        logic [1:0]  e_l2;
        logic        e_vlan;
        logic [4:0]  e_l3;
        logic [2:0]  e_l4;
        logic [7:0]  e_t;
        logic [7:0]  e_u;
    } vec_t;

    localparam int NV = 16;
    // e_t / e_u of 255 mean: no tagged halfword / no data marker
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0800, 4'd5,  8'd6,  4'd5, 8'd32, 2'b01, 1'b0, 5'b00001, 3'b001, 8'd17,  8'd27},
        '{1'b0, 16'h0800, 4'd5,  8'd17, 4'd5, 8'd24, 2'b01, 1'b0, 5'b00001, 3'b010, 8'd17,  8'd21},
        '{1'b0, 16'h0800, 4'd7,  8'd6,  4'd8, 8'd40, 2'b01, 1'b0, 5'b00001, 3'b001, 8'd21,  8'd37},
        '{1'b1, 16'h0800, 4'd6,  8'd17, 4'd5, 8'd28, 2'b01, 1'b1, 5'b00001, 3'b010, 8'd21,  8'd25},
        '{1'b0, 16'h0800, 4'd5,  8'd1,  4'd5, 8'd24, 2'b01, 1'b0, 5'b00001, 3'b100, 8'd255, 8'd255},
        '{1'b0, 16'h86DD, 4'd5,  8'd6,  4'd5, 8'd40, 2'b01, 1'b0, 5'b00010, 3'b001, 8'd27,  8'd37},
        '{1'b1, 16'h86DD, 4'd5,  8'd17, 4'd5, 8'd36, 2'b01, 1'b1, 5'b00010, 3'b010, 8'd29,  8'd33},
        '{1'b0, 16'h86DD, 4'd5,  8'd58, 4'd5, 8'd30, 2'b01, 1'b0, 5'b00010, 3'b100, 8'd255, 8'd255},
        '{1'b0, 16'h0806, 4'd5,  8'd6,  4'd5, 8'd16, 2'b01, 1'b0, 5'b00100, 3'b000, 8'd255, 8'd255},
        '{1'b0, 16'h8035, 4'd5,  8'd6,  4'd5, 8'd16, 2'b01, 1'b0, 5'b01000, 3'b000, 8'd255, 8'd255},
        '{1'b0, 16'h8137, 4'd5,  8'd6,  4'd5, 8'd16, 2'b01, 1'b0, 5'b10000, 3'b000, 8'd255, 8'd255},
        '{1'b0, 16'h0040, 4'd5,  8'd6,  4'd5, 8'd16, 2'b10, 1'b0, 5'b00000, 3'b000, 8'd255, 8'd255},
        '{1'b0, 16'h0800, 4'd3,  8'd6,  4'd2, 8'd32, 2'b01, 1'b0, 5'b00001, 3'b001, 8'd17,  8'd27},
        '{1'b1, 16'h0100, 4'd5,  8'd6,  4'd5, 8'd16, 2'b10, 1'b1, 5'b00000, 3'b000, 8'd255, 8'd255},
        '{1'b0, 16'h9000, 4'd5,  8'd6,  4'd5, 8'd16, 2'b01, 1'b0, 5'b00000, 3'b000, 8'd255, 8'd255},
        '{1'b0, 16'h0800, 4'd15, 8'd17, 4'd5, 8'd44, 2'b01, 1'b0, 5'b00001, 3'b010, 8'd37,  8'd41}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] gen_word(input vec_t v, input int i);
        int n;
        n = v.vlan ? 9 : 7;
        if (i < 6) return 16'hA000 + 16'(i);
        if (i == 6) return v.vlan ? 16'h8100 : v.etype;
        if (v.vlan && i == 7) return 16'h0005;
        if (v.vlan && i == 8) return v.etype;
        if (v.etype == 16'h0800 && i == n) return {4'h4, v.ihl, 8'h00};
        if (v.etype == 16'h0800 && i == n + 4) return {8'h40, v.proto};
        if (v.etype == 16'h86DD && i == n) return 16'h6000;
        if (v.etype == 16'h86DD && i == n + 3) return {v.proto, 8'h40};
        return {v.doff, 12'h345};
    endfunction

    task automatic send_frame(input vec_t v, input int gap, input int limit,
                              output int first_t, output int tag_cnt,
                              output int ud_idx, output int ud_cnt);
        first_t = 255; tag_cnt = 0; ud_idx = 255; ud_cnt = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            hw_valid = 1'b1; sof = (i == 0); hw_data = gen_word(v, i);
            #1;
            if (csum_tag) begin tag_cnt++; if (first_t == 255) first_t = i; end
            if (user_start) begin ud_cnt++; ud_idx = i; end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                hw_valid = 1'b0; sof = 1'b0; hw_data = 16'hFFFF;
                #1;
                if (csum_tag) tag_cnt++;
                if (user_start) ud_cnt++;
            end
        end
        @(negedge clk);
        hw_valid = 1'b0; sof = 1'b0;
        #1;
    endtask

    task automatic chk_row(input vec_t v, input int first_t, input int tag_cnt,
                           input int ud_idx, input int ud_cnt);
        chk("R2 link", int'(l2_kind), int'(v.e_l2));
        chk("R3 vlan", int'(vlan), int'(v.e_vlan));
        chk("R4 network", int'(l3_kind), int'(v.e_l3));
        chk("R5 R6 transport", int'(l4_kind), int'(v.e_l4));
        chk("R7 first tagged", first_t, int'(v.e_t));
        chk("R7 tagged count", tag_cnt, (v.e_t == 8'd255) ? 0 : int'(v.nw) - int'(v.e_t));
        chk("R8 R9 data index", ud_idx, int'(v.e_u));
        chk("R8 R9 data pulses", ud_cnt, (v.e_u == 8'd255) ? 0 : 1);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int ft, tc, ui, uc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state
        chk("R12 reset flags", int'({l2_kind, vlan, l3_kind, l4_kind}), 0);
        chk("R12 reset strobes", int'({csum_tag, user_start}), 0);

        // R1: words before the first start-of-frame are ignored
        uc = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            hw_valid = 1'b1; sof = 1'b0; hw_data = (i == 6) ? 16'h0800 : 16'h4506;
            #1;
            if (csum_tag || user_start) uc++;
        end
        @(negedge clk); hw_valid = 1'b0; #1;
        chk("R1 pre-frame flags", int'({l2_kind, vlan, l3_kind, l4_kind}), 0);
        chk("R1 pre-frame strobes", uc, 0);

        // table walk
        for (int r = 0; r < NV; r++) begin
            send_frame(VECS[r], 0, int'(VECS[r].nw), ft, tc, ui, uc);
            chk_row(VECS[r], ft, tc, ui, uc);
        end

        // R11: idle cycles between halfwords do not move anything
        send_frame(VECS[0], 2, int'(VECS[0].nw), ft, tc, ui, uc);
        chk("R11 gap data index", ui, 27);
        chk("R11 gap data pulses", uc, 1);
        chk("R11 gap tagged count", tc, 32 - 17);
        chk("R11 gap transport", int'(l4_kind), 1);

        // R10: flags held between frames
        repeat (5) @(negedge clk);
        #1;
        chk("R10 hold transport", int'(l4_kind), 1);
        chk("R10 hold network", int'(l3_kind), 1);

        // R10: new start-of-frame mid-frame clears flags on the next edge
        send_frame(VECS[3], 0, 12, ft, tc, ui, uc);
        chk("R10 partial vlan", int'(vlan), 1);
        @(negedge clk);
        hw_valid = 1'b1; sof = 1'b1; hw_data = 16'hA000;
        @(negedge clk);
        hw_valid = 1'b0; sof = 1'b0;
        #1;
        chk("R10 sof clears", int'({l2_kind, vlan, l3_kind, l4_kind}), 0);

        // R12: reset in the middle of a run
        send_frame(VECS[1], 0, 16, ft, tc, ui, uc);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R12 mid-run reset", int'({l2_kind, vlan, l3_kind, l4_kind}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule